// File: doc/BRIEF.md
# Shared-Select Six-Channel Switch Control Slave

This block is the serial control port of a six-channel output switch. A host sends 16-bit frames over a four-wire serial link. Each frame is one instruction byte and then one data byte, most significant bit first. The block keeps three pieces of state:

- a six-bit on/off register for the channels;
- a six-bit register that chooses, per channel, between serial control and parallel control;
- a set of sticky fault latches. These hold a two-bit code per channel plus one over-temperature bit.

During every frame it addresses, the block returns diagnostic or register contents on its serial output.

Several slaves can share one chip select. The block inspects the two leading instruction bits and takes part only when they read `10`. Until it has made that decision, it leaves its output undriven. If the frame is not meant for it, it keeps the output undriven for the rest of the frame and changes nothing.

The serial pins are sampled by a fast system clock. The block finds the edges of the serial clock and of the chip select from those samples. A write, and the clearing of latched faults, happen when chip select rises, and only if the frame carried exactly sixteen serial clocks.

Top module: `chan_switch_spi`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first write, `ch_off` is `111111` (all channels off), `ch_par` is `000000` (all channels under serial control), all fault latches are clear and `so_oe` is 0.
- R2: A frame whose instruction bits 7:6 are not `10` is ignored: `so_oe` stays 0 for the whole frame and no register or latch changes.
- R3: In an addressed frame, `so_oe` is 0 during bit times 0 and 1, and is 1 from bit time 2 through bit time 15. Bit time k starts after the k-th falling serial clock edge (bit time 0 starts at the chip-select fall). SI is sampled on rising edges.
- R4: In an addressed frame, bit times 2..7 carry, in this order: the common fault flag, the over-temperature flag, channel 6 code (high bit first), then channel 5 code (high bit first).
- R5: Instruction bits 7:2 = `100110` write data bits 7:2 into `ch_off`, with data bit 7 going to channel 6 and data bit 2 to channel 1; 1 = off. Data bits 1:0 are ignored. Bit times 8..15 return the codes of channels 4 down to 1.
- R6: Instruction bits 7:2 = `101010` write data bits 7:2 into `ch_par` with the same channel order; 1 = parallel. Bit times 8..15 return the codes of channels 4..1.
- R7: Instruction bits 7:2 = `100101` (read `ch_off`) and `101001` (read `ch_par`) return that register during bit times 8..13, channel 6 first, then two 1 bits. Neither instruction changes any state.
- R8: Any other addressed instruction changes nothing. Its bit times 8..15 carry the codes of channels 4..1, exactly as a diagnostic read does.
- R9: A frame with any number of rising serial clock edges other than 16 changes no register and clears no latch.
- R10: Each bit of `chan_fault` and `over_temp` is held in a sticky latch once seen high. The common fault flag is the OR of the twelve channel latches. The returned values are those latched at the chip-select fall.
- R11: Only a complete diagnostic read clears the latches. That is instruction bits 7:2 = `100000`, with exactly 16 clocks, taking effect at the chip-select rise. After clearing, the latches reload from the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Shared chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, valid when `so_oe` is 1 |
| so_oe | output | 1 | Drive enable for `so`; 0 means high impedance |
| chan_fault | input | 12 | Fault codes; bits 2i+1:2i belong to channel i+1 |
| over_temp | input | 1 | Over-temperature indication |
| ch_off | output | 6 | Channel off register; bit i is channel i+1 |
| ch_par | output | 6 | Parallel-mode register; bit i is channel i+1 |

## Verification
Every serial pin passes through a two-flop synchronizer, so a change on `sck` or `cs_n` shows up in the block's state on the third rising `clk` edge after it. `so`, `so_oe` and the register outputs therefore settle three system clocks after the serial edge that causes them. The bench holds each serial level for eight system clocks. It samples `so` and `so_oe` on a falling `clk` edge just before it raises `sck`, which is at least eight clocks after the falling edge that set the bit. It reads `ch_off` and `ch_par` ten clocks after raising `cs_n`. Fault inputs are changed at least ten clocks before a frame starts, so each one is latched before the chip-select fall takes its snapshot.

// File: rtl/chan_switch_spi.sv
module chan_switch_spi #(
  parameter int SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        cs_n,
  input  logic        si,
  output logic        so,
  output logic        so_oe,
  input  logic [11:0] chan_fault,
  input  logic        over_temp,
  output logic [5:0]  ch_off,
  output logic [5:0]  ch_par
);
  localparam logic [5:0] OP_WR_OFF = 6'b100110;
  localparam logic [5:0] OP_RD_OFF = 6'b100101;
  localparam logic [5:0] OP_WR_PAR = 6'b101010;
  localparam logic [5:0] OP_RD_PAR = 6'b101001;
  localparam logic [5:0] OP_DIAG   = 6'b100000;

  logic [SYNC:0]   sck_p, cs_p;
  logic [SYNC-1:0] si_p;
  logic [15:0] rx;
  logic [4:0]  rcnt, fcnt;
  logic        addr_q;
  logic [5:0]  ins;
  logic [13:0] snap;
  logic [11:0] diag;
  logic        ot_l;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[SYNC-1:0], sck};
      cs_p  <= {cs_p[SYNC-1:0], cs_n};
      si_p  <= {si_p[SYNC-2:0], si};
    end

  wire cs_now   = cs_p[SYNC-1];
  wire si_now   = si_p[SYNC-1];
  wire sck_rise = ~cs_now &  sck_p[SYNC-1] & ~sck_p[SYNC];
  wire sck_fall = ~cs_now & ~sck_p[SYNC-1] &  sck_p[SYNC];
  wire cs_fall  = ~cs_now &  cs_p[SYNC];
  wire cs_rise  =  cs_now & ~cs_p[SYNC];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx <= '0; rcnt <= '0; fcnt <= '0; addr_q <= 1'b0; ins <= '0; snap <= '0;
    end else if (cs_now | cs_fall) begin
      rcnt   <= '0;
      fcnt   <= '0;
      addr_q <= 1'b0;
      if (cs_fall) snap <= {|diag, ot_l, diag};
    end else begin
      if (sck_rise) begin
        rx <= {rx[14:0], si_now};
        if (rcnt != 5'd31) rcnt <= rcnt + 5'd1;
        if (rcnt == 5'd1) addr_q <= ({rx[0], si_now} == 2'b10);
        if (rcnt == 5'd7) ins <= rx[6:1];
      end
      if (sck_fall && fcnt != 5'd31) fcnt <= fcnt + 5'd1;
    end

  wire done = cs_rise & addr_q & (rcnt == 5'd16);
  wire clr  = done & (ins == OP_DIAG);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ch_off <= '1;
      ch_par <= '0;
      diag   <= '0;
      ot_l   <= 1'b0;
    end else begin
      if (done && ins == OP_WR_OFF) ch_off <= rx[7:2];
      if (done && ins == OP_WR_PAR) ch_par <= rx[7:2];
      diag <= clr ? chan_fault : (diag | chan_fault);
      ot_l <= clr ? over_temp  : (ot_l | over_temp);
    end

  wire [7:0] low = (ins == OP_RD_OFF) ? {ch_off, 2'b11} :
                   (ins == OP_RD_PAR) ? {ch_par, 2'b11} : snap[7:0];
  wire [15:0] word = {2'b00, snap[13:8], low};

  assign so_oe = ~cs_now & addr_q & (fcnt >= 5'd2) & (fcnt <= 5'd15);
  assign so    = so_oe & word[4'd15 - fcnt[3:0]];

  assert_oe_after_addr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (rcnt >= 5'd2));
  assert_off_only_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(ch_off));
  assert_par_only_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(ch_par));
  assert_short_long_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && rcnt != 5'd16) |=> ($stable(ch_off) && $stable(ch_par)));
  assert_sticky_faults_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> (((diag & $past(diag)) == $past(diag)) && (ot_l || !$past(ot_l))));
endmodule

// File: tb/chan_switch_spi_test.sv
module chan_switch_spi_test;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, over_temp = 1'b0;
  logic [11:0] chan_fault = '0;
  logic so, so_oe;
  logic [5:0] ch_off, ch_par;

  chan_switch_spi uut (.clk, .rst_n, .sck, .cs_n, .si, .so, .so_oe,
                       .chan_fault, .over_temp, .ch_off, .ch_par);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [5:0] m_off = 6'h3F, m_par = 6'h00;
  logic [11:0] m_diag = '0;
  logic m_ot = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [15:0] w);
    logic [7:0] low;
    case (w[15:10])
      6'b100101: low = {m_off, 2'b11};
      6'b101001: low = {m_par, 2'b11};
      default:   low = m_diag[7:0];
    endcase
    return {2'b00, |m_diag, m_ot, m_diag[11:8], low};
  endfunction

  function automatic string tag(input logic [15:0] w, input int n);
    if (w[15:14] != 2'b10) return "R2";
    if (n != 16) return "R9";
    case (w[15:10])
      6'b100110: return "R5";
      6'b101010: return "R6";
      6'b100101, 6'b101001: return "R7";
      6'b100000: return "R11";
      default: return "R8";
    endcase
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_faults(input logic [11:0] f, input logic t);
    @(negedge clk);
    chan_fault = f; over_temp = t;
    m_diag |= f; m_ot |= t;
    wait_clk(10);
  endtask

  task automatic frame(input logic [15:0] w, input int n);
    logic [15:0] sv = '0, ov = '0, ew, eo;
    bit addr = (w[15:14] == 2'b10);
    string t = tag(w, n);
    ew = exp_word(w);
    eo = '0;
    for (int k = 2; k < 16; k++) if (addr && k < n) eo[15-k] = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    wait_clk(8);
    if (n == 0) begin sv[15] = so; ov[15] = so_oe; end
    for (int k = 0; k < n; k++) begin
      si = (k < 16) ? w[15-k] : 1'b0;
      wait_clk(8);
      if (k < 16) begin sv[15-k] = so; ov[15-k] = so_oe; end
      sck = 1'b1; wait_clk(8);
      sck = 1'b0;
    end
    wait_clk(8);
    cs_n = 1'b1;
    wait_clk(10);
    check(ov == eo, t, {16'h0, ov}, {16'h0, eo});
    check((sv & eo) == (ew & eo), (t == "R2") ? "R4" : t, {16'h0, sv & eo}, {16'h0, ew & eo});
    if (addr && n == 16) begin
      case (w[15:10])
        6'b100110: m_off = w[7:2];
        6'b101010: m_par = w[7:2];
        6'b100000: begin m_diag = chan_fault; m_ot = over_temp; end
        default: ;
      endcase
    end
    check(ch_off == m_off && ch_par == m_par, t, {20'h0, ch_off, ch_par}, {20'h0, m_off, m_par});
  endtask

  initial begin
    void'($urandom(32'd7321));
    wait_clk(5);
    check(ch_off == 6'h3F && ch_par == 6'h00 && so_oe == 1'b0, "R1", {19'h0, so_oe, ch_off, ch_par}, 32'hFC0);
    rst_n = 1'b1;
    wait_clk(5);
    frame(16'h8000, 16);
    check(1'b1, "R1", 0, 0);
    frame({6'b100110, 2'b01, 8'b1010_1011}, 16);
    frame({6'b100101, 2'b00, 8'h00}, 16);
    frame({6'b101010, 2'b11, 8'b0110_0100}, 16);
    frame({6'b101001, 2'b10, 8'hFF}, 16);
    frame({6'b010110, 2'b00, 8'h00}, 16);
    frame({6'b110110, 2'b00, 8'hFF}, 16);
    set_faults(12'b10_00_01_00_00_11, 1'b1);
    frame({6'b100110, 2'b00, 8'h00}, 16);
    set_faults(12'h000, 1'b0);
    frame({6'b111111, 2'b00, 8'h00}, 16);
    frame({6'b100000, 2'b00, 8'h00}, 15);
    frame({6'b100000, 2'b00, 8'h00}, 17);
    frame({6'b100110, 2'b00, 8'h00}, 15);
    frame({6'b101010, 2'b00, 8'hFF}, 17);
    frame({6'b100000, 2'b00, 8'h00}, 16);
    frame({6'b100000, 2'b00, 8'h00}, 16);
    set_faults(12'b00_11_00_00_10_00, 1'b0);
    frame({6'b100000, 2'b01, 8'h5A}, 16);
    frame({6'b100000, 2'b01, 8'h5A}, 16);
    for (int i = 0; i < 230; i++) begin
      logic [15:0] w = 16'($urandom);
      int n = 16;
      int r = int'($urandom % 10);
      if ($urandom % 4 == 0)
        set_faults(12'($urandom & $urandom & $urandom), ($urandom % 8) == 0);
      if (r < 7) begin
        w[15:14] = 2'b10;
        case ($urandom % 6)
          0: w[13:10] = 4'b0110;
          1: w[13:10] = 4'b0101;
          2: w[13:10] = 4'b1010;
          3: w[13:10] = 4'b1001;
          4: w[13:10] = 4'b0000;
          default: ;
        endcase
      end
      if ($urandom % 8 == 0) n = int'($urandom % 20);
      frame(w, n);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule